// File: doc/BRIEF.md
# Split Enable-Clear Interrupt Controller

The block gathers five interrupt sources (an external input, two timers, an asynchronous serial port and a synchronous serial port) behind one 16-bit host register. Its two byte lanes do different jobs. A write to the low lane sets the per-source enable mask. A write to the high lane acknowledges pending interrupts, where each 1 drops the matching pending latch. A read returns the enable mask in the low byte and the pending latches in the high byte. Those latches are state inside the block, not an echo of the last write.

A source pulses its `src_evt` bit when it wants service. The event is latched only if the source is enabled at that moment. The host sees a single `irq_out` line that is the OR of every pending source that is also enabled. In the interrupt handler, the host reads the register, services the sources, and writes the acknowledge bits back.

Top module: `irq_enclr_ctrl`

## Requirements
- R1: After reset, every enable bit and every pending latch is 0, so `rd_data` reads 0x0000 and `irq_out` is low.
- R2: A write with `wr_en` and `wr_be[0]` high loads the enable mask from `wr_data[4:0]`. Bit 0 is external, bit 1 is timer 1, bit 2 is timer 2, bit 3 is asynchronous serial and bit 4 is synchronous serial. The mask reads back on `rd_data[4:0]` from the next cycle, and `rd_data[7:5]` and `rd_data[15:13]` always read 0.
- R3: If `src_evt[i]` is high on a clock edge while enable bit i is set, pending bit i is set after that edge and reads on `rd_data[8+i]`.
- R4: If `src_evt[i]` is high on an edge while enable bit i is clear, the event is ignored. This holds even when the same edge writes the enable bit to 1, because the value held before the edge decides.
- R5: A write with `wr_en` and `wr_be[1]` high clears pending bit i wherever `wr_data[8+i]` is 1. A 0 in any of those positions leaves its latch unchanged.
- R6: The two lanes are independent. A high-lane write never changes the enables, and a low-lane write never clears a pending latch.
- R7: If a source's event and its clear arrive on the same edge, the pending bit ends up set.
- R8: `irq_out` is high exactly when some source is both pending and enabled. Clearing an enable masks the output but keeps the latch.
- R9: A pending latch stays set after its event input returns low, until it is cleared or the block is reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 5 | Per-source interrupt event, sampled each edge |
| wr_en | input | 1 | Host write strobe |
| wr_be | input | 2 | Byte lane enables: bit 0 for the enable lane, bit 1 for the acknowledge lane |
| wr_data | input | 16 | Host write data |
| rd_data | output | 16 | Enables in bits 4:0, pending latches in bits 12:8 |
| irq_out | output | 1 | Combined interrupt request to the host |

## Verification
Directed sequences cover the cases where the two lanes could interfere with each other. They write each lane alone and both lanes together, write acknowledge patterns that contain zeros, raise an event on the same edge as its clear, and raise an event on the same edge as an enable write. These cases separate a design that latches on the old mask from one that latches on the new mask. They also separate set-wins from clear-wins, and masked output from lost state. Random cycles then mix events, enable writes and acknowledges with random byte enables. Every cycle compares the full read word and the output line against a reference model, which catches swapped bit positions and a wrong lane decode.

// File: rtl/irq_enclr_ctrl.sv
module irq_enclr_ctrl #(
  parameter int NSRC    = 5,
  parameter int DW      = 16,
  parameter int CLR_LSB = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_evt,
  input  logic            wr_en,
  input  logic [1:0]      wr_be,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  output logic            irq_out
);
  localparam int CLR_MSB = CLR_LSB + NSRC - 1;

  logic [NSRC-1:0] en_q, pend_q;
  logic [NSRC-1:0] set_v, clr_v;
  logic            en_wr;
  logic            unused_wr_bits;

  assign en_wr = wr_en && wr_be[0];
  assign set_v = src_evt & en_q;
  assign clr_v = (wr_en && wr_be[1]) ? wr_data[CLR_MSB:CLR_LSB] : '0;
  assign unused_wr_bits = ^{wr_data[CLR_LSB-1:NSRC], wr_data[DW-1:CLR_MSB+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_wr) en_q <= wr_data[NSRC-1:0];
      pend_q <= (pend_q & ~clr_v) | set_v;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[NSRC-1:0] = en_q;
    rd_data[CLR_MSB:CLR_LSB] = pend_q;
  end

  assign irq_out = |(pend_q & en_q);

  // R3
  latch_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src_evt & rd_data[NSRC-1:0])) |=>
      ((rd_data[CLR_MSB:CLR_LSB] & $past(src_evt & rd_data[NSRC-1:0])) == $past(src_evt & rd_data[NSRC-1:0])));

  // R4
  no_spurious_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rd_data[CLR_MSB:CLR_LSB] & ~$past(rd_data[CLR_MSB:CLR_LSB])
               & ~$past(src_evt & rd_data[NSRC-1:0])) == '0));

  // R5
  ack_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[1]) |=>
      ((rd_data[CLR_MSB:CLR_LSB] & $past(wr_data[CLR_MSB:CLR_LSB] & ~(src_evt & rd_data[NSRC-1:0]))) == '0));

  // R6
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_be[0]) |=> $stable(rd_data[NSRC-1:0]));

  // R8
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src_evt & rd_data[NSRC-1:0])) && !(wr_en && wr_be[0]) |=> irq_out);
endmodule

// File: tb/irq_enclr_ctrl_test.sv
`timescale 1ns/1ps
module irq_enclr_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  src_evt = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_be = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  logic [4:0] m_en = '0, m_pend = '0;

  always #10 clk = ~clk;

  irq_enclr_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .wr_en(wr_en),
    .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
  );

  function automatic logic [15:0] exp_rd(logic [4:0] e, logic [4:0] p);
    return {3'b000, p, 3'b000, e};
  endfunction

  function automatic logic exp_irq(logic [4:0] e, logic [4:0] p);
    return |(e & p);
  endfunction

  task automatic check(string req, logic [15:0] act_rd, logic act_irq);
    checks++;
    if (act_rd !== exp_rd(m_en, m_pend) || act_irq !== exp_irq(m_en, m_pend)) begin
      errors++;
      $display("FAIL %s rd_data=%h irq=%b expected rd_data=%h irq=%b",
               req, act_rd, act_irq, exp_rd(m_en, m_pend), exp_irq(m_en, m_pend));
    end
  endtask

  task automatic step(logic [4:0] evt, logic we, logic [1:0] be, logic [15:0] d, string req);
    logic [4:0] clr;
    src_evt = evt; wr_en = we; wr_be = be; wr_data = d;
    @(posedge clk);
    clr = (we && be[1]) ? d[12:8] : 5'd0;
    m_pend = (m_pend & ~clr) | (evt & m_en);
    if (we && be[0]) m_en = d[4:0];
    @(negedge clk);
    src_evt = '0; wr_en = 1'b0; wr_be = '0; wr_data = '0;
    check(req, rd_data, irq_out);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired rd_data=%h expected run to finish", rd_data);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset", rd_data, irq_out);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", rd_data, irq_out);

    step(5'd0, 1'b1, 2'b01, 16'h001F, "R2 all enables");
    step(5'd0, 1'b1, 2'b01, 16'hFFE5, "R2 unused bits read zero");
    step(5'b11111, 1'b0, 2'b00, 16'h0000, "R3 R4 events with partial mask");
    step(5'd0, 1'b0, 2'b00, 16'h0000, "R9 latch held");
    step(5'd0, 1'b1, 2'b10, 16'h00FF, "R5 zero clears no effect");
    step(5'd0, 1'b1, 2'b10, 16'h0100, "R5 R6 clear external only");
    step(5'd0, 1'b1, 2'b01, 16'h1F00, "R6 R8 disable masks irq keeps latch");
    step(5'd0, 1'b1, 2'b01, 16'h0004, "R8 re-enable timer 2");
    step(5'd0, 1'b1, 2'b10, 16'h0400, "R5 clear timer 2");
    step(5'b00100, 1'b1, 2'b10, 16'h0400, "R7 set wins over clear");
    step(5'b00010, 1'b1, 2'b01, 16'h0002, "R4 old enable decides");
    step(5'b00010, 1'b0, 2'b00, 16'h0000, "R3 timer 1 latches");
    step(5'b11111, 1'b1, 2'b11, 16'h1F1F, "R5 R6 both lanes");
    step(5'd0, 1'b1, 2'b11, 16'h1F00, "R5 R8 clear all disable all");

    for (int i = 0; i < 400; i++) begin
      logic [4:0] ev;
      logic [15:0] d;
      ev = 5'($urandom) & 5'($urandom);
      d  = 16'($urandom);
      step(ev, 1'($urandom), 2'($urandom), d, "R3 R8 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule